// File: doc/BRIEF.md
# Interrupt Distributor with Sixteen-Bit CPU Targets

This block collects interrupt lines from devices and presents, to each of several CPU interfaces, the lowest-numbered interrupt that is pending, enabled and routed to that interface. Each interrupt ID has a 16-bit CPU target field, so one source can be routed to any subset of up to sixteen CPU interfaces. Source IDs run from 0 upward and never reach 510. IDs 0 to 31 are private to each CPU interface. Each interface has its own 32 private input lines, and its own enable and pending state for them. IDs from 32 upward are shared lines that all interfaces see.

Software configures the block over a simple synchronous bus. Each access carries the number of the CPU making it, and that number selects the private bank. Through this bus it sets and clears enables, picks level or rising-edge triggering, and programs the target fields. A CPU interface consumes an edge-triggered interrupt by pulsing its acknowledge input while that interrupt is presented. Level-triggered interrupts follow their input line.

Top module: `irq_distributor`

## Requirements
- R1: After reset every `irq_valid` bit is 0 and every `irq_id` field is 0. Bit 0 of the control word at byte address 0x000 enables forwarding. While it is 0, no CPU interface is signalled, and it reads back as written.
- R2: The word at 0x004 is read-only. Its bits 4:0 read NUM_IRQ/32-1, which encodes a line count of (value+1)*32. Writes to it change nothing.
- R3: The enable-set bank at 0x100 and the enable-clear bank at 0x180 hold the bit for ID n at bit n mod 32 of the word at offset (n/32)*4. Writing 1 sets or clears that enable, and writing 0 leaves it unchanged. Either bank reads back the current enables.
- R4: The enable bits for IDs 0–31 (word 0 of both banks) are held separately for each CPU interface. An access to word 0 reads or changes only the bank of the CPU named by `bus_cpu`. The pending state of private lines is likewise per interface.
- R5: The trigger bank at 0x300 uses the same bit layout as the enable banks, with 1 meaning rising edge and 0 meaning active-high level. IDs 0–15 always read 1 (edge) and ignore writes.
- R6: An edge-triggered interrupt becomes pending on a 0→1 transition of its line and stays pending after the line falls. It is cleared when the CPU interface presenting it pulses `cpu_ack`. A level-triggered interrupt is pending while its line is high, and `cpu_ack` does not affect it.
- R7: The 16-bit target field of ID n sits in the word at 0x800 + ((2n) with bits 1:0 cleared), at bit (n mod 2)*16, and bit c selects CPU interface c. A shared interrupt is presented only to the interfaces whose bit is set, to several at once if several bits are set. Target fields read back.
- R8: Target words for IDs 0–31 (0x800–0x83F) read the requesting CPU's one-hot bit in both 16-bit halves, and writes to them are ignored.
- R9: Each CPU interface is presented the lowest ID that is pending, enabled and routed to it, with `irq_valid` high. The output is registered: a level change at the input reaches the output after two clock edges. Bus reads return data one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | CPU_W | Number of the CPU making the bus access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| priv_irq | input | NUM_CPU*32 | Private lines, bits c*32+i for ID i of CPU c |
| shr_irq | input | NUM_IRQ-32 | Shared lines, bit j for ID j+32 |
| cpu_ack | input | NUM_CPU | Acknowledge of the presented interrupt, per CPU |
| irq_valid | output | NUM_CPU | An interrupt is presented to CPU c |
| irq_id | output | NUM_CPU*ID_W | Presented ID, field c for CPU c |

## Verification
Random shared and private level patterns are combined with random enables and random multi-bit targets, and every interface's pick is compared with a model. This shows whether routing, enables and lowest-ID ordering combine correctly when several sources compete. Directed sequences cover the cases random levels cannot reach. A single-cycle pulse tells edge latching apart from level following. An acknowledge applied to a level source and then to an edge source tells the two clearing rules apart. The same private ID is enabled on one interface only, which tells banked enables apart from shared ones. Writes to the fixed fields and to the private target words show that they change nothing.

// File: rtl/dist_pkg.sv
package dist_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned SRC_LIMIT = 510;
  localparam int unsigned TGT_W     = 16;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_ENSET, RG_ENCLR, RG_TRIG, RG_TGT
  } rgn_e;

  function automatic rgn_e rgn_of(input logic [ADDR_W-1:0] a);
    if (a == 12'h000) return RG_CTRL;
    if (a == 12'h004) return RG_TYPE;
    if (a[11:7] == 5'b00010) return RG_ENSET;
    if (a[11:7] == 5'b00011) return RG_ENCLR;
    if (a[11:7] == 5'b00110) return RG_TRIG;
    if (a[11]) return RG_TGT;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/dist_pend.sv
module dist_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  // edge sources: set on rise (set beats clear), held until acknowledged
  // level sources: follow the line
  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= line;
      pend <= (edge_mode & ((pend & ~clr) | (line & ~prev))) | (~edge_mode & line);
    end
  end
endmodule

// File: rtl/dist_pick.sv
module dist_pick #(
  parameter int N    = 64,
  parameter int ID_W = 6
) (
  input  logic [N-1:0]    req,
  output logic            found,
  output logic [ID_W-1:0] id
);
  always_comb begin
    found = 1'b0;
    id    = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        id    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  parameter int CPU_W   = $clog2(NUM_CPU),
  parameter int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CPU_W-1:0]        bus_cpu,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [11:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_CPU*32-1:0]   priv_irq,
  input  logic [NUM_IRQ-33:0]     shr_irq,
  input  logic [NUM_CPU-1:0]      cpu_ack,
  output logic [NUM_CPU-1:0]      irq_valid,
  output logic [NUM_CPU*ID_W-1:0] irq_id
);
  import dist_pkg::*;

  localparam int NS = NUM_IRQ - 32;
  localparam int NW = NUM_IRQ / 32;

  rgn_e rg;
  logic [4:0] bank_word;
  logic [8:0] tgt_word;
  logic [15:0] own_bit;

  logic ctrl_en;
  logic [31:0] en_priv [NUM_CPU];
  logic [NS-1:0] en_shr;
  logic [15:0] trig_priv;
  logic [NS-1:0] trig_shr;
  logic [NUM_CPU-1:0] tgt_q [NS];

  logic [NS-1:0] shr_pend, shr_clr, lim;
  logic [31:0] priv_clr [NUM_CPU];
  logic [NS-1:0] tgt_col [NUM_CPU];
  logic [NUM_CPU-1:0] pick_found;
  logic [ID_W-1:0] pick_id [NUM_CPU];
  logic [NUM_CPU-1:0] ack_hit;
  logic [31:0] rd_val;

  assign rg        = rgn_of(bus_addr);
  assign bank_word = bus_addr[6:2];
  assign tgt_word  = bus_addr[10:2];
  assign own_bit   = 16'(1) << bus_cpu;
  assign ack_hit   = cpu_ack & irq_valid;

  // sources at or beyond the hard limit are never forwarded
  for (genvar j = 0; j < NS; j++) begin : g_lim
    assign lim[j] = ((j + 32) < SRC_LIMIT);
  end

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      en_shr    <= '0;
      trig_priv <= '0;
      trig_shr  <= '0;
      for (int c = 0; c < NUM_CPU; c++) en_priv[c] <= '0;
      for (int j = 0; j < NS; j++) tgt_q[j] <= '0;
    end else if (bus_wr) begin
      if (rg == RG_CTRL) ctrl_en <= bus_wdata[0];
      if (rg == RG_ENSET && bank_word == 5'd0)
        en_priv[bus_cpu] <= en_priv[bus_cpu] | bus_wdata;
      if (rg == RG_ENCLR && bank_word == 5'd0)
        en_priv[bus_cpu] <= en_priv[bus_cpu] & ~bus_wdata;
      if (rg == RG_TRIG && bank_word == 5'd0)
        trig_priv <= bus_wdata[31:16];
      for (int j = 0; j < NS; j++) begin
        if (int'(bank_word) == (j + 32) / 32) begin
          if (rg == RG_ENSET && bus_wdata[(j + 32) % 32]) en_shr[j] <= 1'b1;
          if (rg == RG_ENCLR && bus_wdata[(j + 32) % 32]) en_shr[j] <= 1'b0;
          if (rg == RG_TRIG) trig_shr[j] <= bus_wdata[(j + 32) % 32];
        end
        if (rg == RG_TGT && int'(tgt_word) == (j + 32) / 2)
          tgt_q[j] <= bus_wdata[((j + 32) % 2) * TGT_W +: NUM_CPU];
      end
    end
  end

  // read path
  always_comb begin
    rd_val = '0;
    case (rg)
      RG_CTRL: rd_val = {31'b0, ctrl_en};
      RG_TYPE: rd_val = {27'b0, 5'(NW - 1)};
      RG_ENSET, RG_ENCLR: begin
        if (bank_word == 5'd0) rd_val = en_priv[bus_cpu];
        for (int j = 0; j < NS; j++)
          if (int'(bank_word) == (j + 32) / 32) rd_val[(j + 32) % 32] = en_shr[j];
      end
      RG_TRIG: begin
        if (bank_word == 5'd0) rd_val = {trig_priv, 16'hFFFF};
        for (int j = 0; j < NS; j++)
          if (int'(bank_word) == (j + 32) / 32) rd_val[(j + 32) % 32] = trig_shr[j];
      end
      RG_TGT: begin
        if (tgt_word < 9'd16) rd_val = {own_bit, own_bit};
        for (int j = 0; j < NS; j++)
          if (int'(tgt_word) == (j + 32) / 2)
            rd_val[((j + 32) % 2) * TGT_W +: NUM_CPU] = tgt_q[j];
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // acknowledge decode: clear the edge pending bit of the presented ID
  always_comb begin
    shr_clr = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      priv_clr[c] = '0;
      for (int i = 0; i < 32; i++)
        if (ack_hit[c] && irq_id[c*ID_W +: ID_W] == ID_W'(i)) priv_clr[c][i] = 1'b1;
      for (int j = 0; j < NS; j++)
        if (ack_hit[c] && irq_id[c*ID_W +: ID_W] == ID_W'(j + 32)) shr_clr[j] = 1'b1;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      for (int j = 0; j < NS; j++)
        tgt_col[c][j] = tgt_q[j][c];
  end

  dist_pend #(.N(NS)) u_shr_pend (
    .clk(clk), .rst(rst), .line(shr_irq), .edge_mode(trig_shr),
    .clr(shr_clr), .pend(shr_pend)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [31:0] pp;
    logic [NUM_IRQ-1:0] req;

    dist_pend #(.N(32)) u_priv_pend (
      .clk(clk), .rst(rst), .line(priv_irq[c*32 +: 32]),
      .edge_mode({trig_priv, 16'hFFFF}), .clr(priv_clr[c]), .pend(pp)
    );

    assign req = {shr_pend & en_shr & tgt_col[c] & lim, pp & en_priv[c]};

    dist_pick #(.N(NUM_IRQ), .ID_W(ID_W)) u_pick (
      .req(req), .found(pick_found[c]), .id(pick_id[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= '0;
      irq_id    <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        irq_valid[c] <= ctrl_en & pick_found[c];
        irq_id[c*ID_W +: ID_W] <= (ctrl_en & pick_found[c]) ? pick_id[c] : '0;
      end
    end
  end
endmodule

// File: rtl/dist_chk.sv
module dist_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input logic               clk,
  input logic               rst,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic               bus_rd,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_rdata,
  input logic [NUM_CPU-1:0] irq_valid,
  input logic               ctrl_en
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    // R1: forwarding off means nothing presented next cycle
    a_r1_gate_off: assert property (@(posedge clk) disable iff (rst)
      !ctrl_en |=> !irq_valid[c]);
  end

  // R2: line-count field
  a_r2_type_value: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 12'h004) |=> bus_rdata == 32'(NUM_IRQ / 32 - 1));

  // R5: fixed edge configuration for IDs 0-15
  a_r5_fixed_trig: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 12'h300) |=> bus_rdata[15:0] == 16'hFFFF);

  // R8: private target words return the requester's bit
  a_r8_own_target: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[11:6] == 6'b100000) |=>
      bus_rdata == {2{16'(1) << $past(bus_cpu)}});
endmodule

bind irq_distributor dist_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst(rst), .bus_cpu(bus_cpu), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_valid(irq_valid), .ctrl_en(ctrl_en)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NI = 64;
  localparam int IDW = 6;

  logic clk = 0, rst = 1;
  logic [1:0] bus_cpu = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NC*32-1:0] priv_irq = '0;
  logic [NI-33:0] shr_irq = '0;
  logic [NC-1:0] cpu_ack = '0;
  logic [NC-1:0] irq_valid;
  logic [NC*IDW-1:0] irq_id;

  int n_chk = 0, n_bad = 0;
  bit [31:0] m_enp [NC];
  bit [31:0] m_ens;
  bit [3:0] m_tgt [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_distributor #(.NUM_CPU(NC), .NUM_IRQ(NI)) uut (
    .clk(clk), .rst(rst), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .priv_irq(priv_irq), .shr_irq(shr_irq), .cpu_ack(cpu_ack),
    .irq_valid(irq_valid), .irq_id(irq_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cpu = 2'(cpu); bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_out(input string req, input int c, input bit v, input int id);
    check(req, {25'b0, irq_valid[c], irq_id[c*IDW +: IDW]}, {25'b0, v, 6'(id)});
  endtask

  task automatic ack(input int c);
    @(negedge clk); cpu_ack[c] = 1;
    @(negedge clk); cpu_ack[c] = 0;
  endtask

  function automatic logic [6:0] model_pick(int c);
    for (int id = 0; id < NI; id++) begin
      if (id < 32) begin
        if (priv_irq[c*32 + id] && m_enp[c][id]) return {1'b1, 6'(id)};
      end else if (shr_irq[id-32] && m_ens[id-32] && m_tgt[id-32][c]) return {1'b1, 6'(id)};
    end
    return 7'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk_out("R1 reset", c, 0, 0);

    // random level phase: R9, R7, R3, R4
    wr(0, 12'h300, 32'h0);
    wr(0, 12'h304, 32'h0);
    wr(0, 12'h000, 32'h1);
    for (int it = 0; it < 40; it++) begin
      if (it % 4 == 0) begin
        for (int c = 0; c < NC; c++) begin
          m_enp[c] = $urandom & 32'hFFFF0000;
          wr(c, 12'h180, 32'hFFFFFFFF);
          wr(c, 12'h100, m_enp[c]);
        end
        m_ens = $urandom;
        wr(0, 12'h184, 32'hFFFFFFFF);
        wr(0, 12'h104, m_ens);
        for (int w = 16; w < 32; w++) begin
          d = $urandom;
          wr(0, 12'(32'h800 + 4*w), d);
          m_tgt[2*w-32] = d[3:0];
          m_tgt[2*w-31] = d[19:16];
        end
      end
      @(negedge clk);
      shr_irq = $urandom;
      for (int c = 0; c < NC; c++) priv_irq[c*32 +: 32] = $urandom & 32'hFFFF0000;
      settle();
      for (int c = 0; c < NC; c++) begin
        logic [6:0] e;
        e = model_pick(c);
        chk_out("R9 random pick", c, e[6], int'(e[5:0]));
      end
    end

    // quiet everything
    @(negedge clk);
    shr_irq = '0; priv_irq = '0;
    for (int c = 0; c < NC; c++) wr(c, 12'h180, 32'hFFFFFFFF);
    wr(0, 12'h184, 32'hFFFFFFFF);
    settle();
    for (int c = 0; c < NC; c++) chk_out("R3 all cleared", c, 0, 0);

    // R8 private target words
    rd(2, 12'h800, d); check("R8 own bit cpu2", d, 32'h00040004);
    wr(2, 12'h80C, 32'h0);
    rd(2, 12'h80C, d); check("R8 write ignored", d, 32'h00040004);
    rd(0, 12'h83C, d); check("R8 own bit cpu0", d, 32'h00010001);

    // R7 targets, R3 enables
    wr(0, 12'h840, 32'h000A0000);
    rd(0, 12'h840, d); check("R7 target readback", d, 32'h000A0000);
    wr(0, 12'h104, 32'h2);
    rd(0, 12'h104, d); check("R3 enable set", d, 32'h2);
    wr(0, 12'h184, 32'h0);
    rd(0, 12'h184, d); check("R3 zero clear no effect", d, 32'h2);
    @(negedge clk); shr_irq[1] = 1;
    settle();
    chk_out("R7 cpu0 not targeted", 0, 0, 0);
    chk_out("R7 cpu1 targeted", 1, 1, 33);
    chk_out("R7 cpu2 not targeted", 2, 0, 0);
    chk_out("R7 cpu3 targeted", 3, 1, 33);

    // R1 forwarding gate
    wr(0, 12'h000, 32'h0);
    settle();
    chk_out("R1 gated", 1, 0, 0);
    rd(0, 12'h000, d); check("R1 ctrl readback", d, 32'h0);
    wr(0, 12'h000, 32'h1);
    settle();
    chk_out("R1 ungated", 1, 1, 33);

    // R6 level ignores acknowledge
    ack(1);
    settle();
    chk_out("R6 level after ack", 1, 1, 33);

    // R9 lowest first
    wr(0, 12'h844, 32'h00000002);
    wr(0, 12'h104, 32'h4);
    @(negedge clk); shr_irq[2] = 1;
    settle();
    chk_out("R9 lowest of 33,34", 1, 1, 33);
    @(negedge clk); shr_irq[1] = 0;
    settle();
    chk_out("R9 next is 34", 1, 1, 34);
    chk_out("R7 cpu3 not on 34", 3, 0, 0);

    // R4 banked private enables
    wr(0, 12'h100, 32'h00100000);
    @(negedge clk); priv_irq[20] = 1; priv_irq[32+20] = 1;
    settle();
    chk_out("R4 cpu0 private 20", 0, 1, 20);
    chk_out("R4 cpu1 bank off", 1, 1, 34);
    rd(1, 12'h100, d); check("R4 cpu1 word0", d, 32'h0);
    rd(0, 12'h100, d); check("R4 cpu0 word0", d, 32'h00100000);
    @(negedge clk); priv_irq = '0; shr_irq = '0;
    wr(0, 12'h180, 32'hFFFFFFFF);

    // R6 edge latch and acknowledge
    wr(0, 12'h304, 32'h00000100);
    rd(0, 12'h304, d); check("R5 trig readback", d, 32'h00000100);
    wr(0, 12'h850, 32'h00000001);
    wr(0, 12'h104, 32'h00000100);
    @(negedge clk); shr_irq[8] = 1;
    @(negedge clk); shr_irq[8] = 0;
    settle();
    chk_out("R6 edge latched", 0, 1, 40);
    ack(0);
    settle();
    chk_out("R6 edge acked", 0, 0, 0);

    // R5 fixed edge on IDs 0-15
    wr(2, 12'h100, 32'h00000020);
    wr(0, 12'h300, 32'h0);
    rd(0, 12'h300, d); check("R5 fixed low half", d, 32'h0000FFFF);
    @(negedge clk); priv_irq[2*32+5] = 1;
    @(negedge clk); priv_irq[2*32+5] = 0;
    settle();
    chk_out("R5 id5 latched as edge", 2, 1, 5);
    ack(2);
    settle();
    chk_out("R5 id5 acked", 2, 0, 0);

    // R2 type word
    rd(0, 12'h004, d); check("R2 type", d, 32'h1);
    wr(0, 12'h004, 32'h1F);
    rd(0, 12'h004, d); check("R2 type write ignored", d, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule